// File: doc/BRIEF.md
# Multi-mode serial flash read sequencer

This block carries out a single-byte read from a serial flash device. A start pulse, which stands for software setting the command register's execute bit, latches the current bus configuration, the address byte registers and the opcode slots. The block then walks through four phases: an opcode phase, an address phase of three or four bytes, a dummy phase of zero to eight clocks, and a data phase that collects one byte. The byte goes into the read-data register. The busy flag, which is the readable image of the execute bit, clears by itself in the same cycle.

The bus configuration sets the lane count of the address phase and of the data phase, each one, two or four lanes wide. It also sets the number of dummy clocks and where the opcode comes from. Four-lane reads take their opcode from programmable slot 4 and two-lane reads from slot 3. One-lane reads use a fixed normal or fast opcode, picked by a fast-read bit. Each serial clock spans two system clocks. The sequencer changes its outputs while the serial clock is low and samples the flash on the rising edge.

Top module: `flash_read_seq`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, busy is 0, rd_data is 0 and io_oe is 0.
- R2: A start pulse while idle pulls cs_n low and raises busy in the next cycle. busy falls by itself when the data phase ends, and in that same cycle rd_data takes the received byte.
- R3: The opcode phase always runs 8 serial clocks on lane 0, MSB first, with io_oe = 4'b0001. The opcode is chosen as follows: four-lane data uses op_slot4, two-lane data uses op_slot3, one-lane data with fast_rd=1 uses 8'h0B, and one-lane data with fast_rd=0 uses 8'h03.
- R4: bus_cfg is decoded as follows. Bit 2 selects four-lane data and takes priority over bit 0, which selects two-lane data. Bit 3 (four-lane address) counts only together with bit 2. Bit 1 (two-lane address) counts only when bit 0 selects two-lane data. Bit 4 selects a 32-bit address.
- R5: The address goes out MSB first. A 32-bit address is {addr_b3, addr_b2, addr_b1, addr_b0}. A 24-bit address is {addr_b2, addr_b1, addr_b0}, and addr_b3 is ignored. The lanes carry the bits as follows: one lane uses io_out[0]; two lanes use io_out[1:0] with bit 1 as the more significant; four lanes use io_out[3:0] with bit 3 as the most significant. The driven lanes have their io_oe bits set.
- R6: The dummy clock count is as follows. With two- or four-lane data it is 8 for a one-lane address, 4 for a two-lane address and 6 for a four-lane address. With one-lane data it is 8 when fast_rd=1 and 0 otherwise.
- R7: The data byte is received MSB first. One lane uses io_in[1]. Two lanes use io_in[1:0]. Four lanes use io_in[3:0]. Lanes outside the mode are ignored. io_oe is 0 throughout the dummy and data phases.
- R8: A read takes exactly 8 + address_bits/address_lanes + dummy + 8/data_lanes rising sck edges. Outputs change only when sck falls, and io_in is sampled as sck rises.
- R9: A start pulse while busy is ignored. Changes to bus_cfg, fast_rd, the address bytes or the slots during a read do not affect that read.
- R10: While idle, cs_n is 1, sck is 0 and io_oe and io_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse: write of the command execute bit |
| bus_cfg | input | 5 | Bus configuration register (mode bits) |
| fast_rd | input | 1 | Fast-read select for one-lane reads |
| addr_b0 | input | 8 | Address bits 7:0 |
| addr_b1 | input | 8 | Address bits 15:8 |
| addr_b2 | input | 8 | Address bits 23:16 |
| addr_b3 | input | 8 | Address bits 31:24 (32-bit mode only) |
| op_slot3 | input | 8 | Opcode for two-lane data reads |
| op_slot4 | input | 8 | Opcode for four-lane data reads |
| busy | output | 1 | Execute bit readback; clears when the read completes |
| rd_data | output | 8 | Read-data register |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
The bench uses the default configuration: four lanes, a 32-bit address register and byte-wide data. That fixed size makes it possible to sweep all 32 bus_cfg encodings against both fast_rd values and two addresses. The sweep covers every opcode source, each address lane count with each address width, and every dummy count, including the zero-dummy path. A flash model in the bench decodes the opcode and address using its own lane arithmetic. It drives junk on the unused input lanes and counts the serial edges. Some of the reads are disturbed by a second start pulse and by changed configuration inputs partway through.

// File: rtl/frs_pkg.sv
package frs_pkg;
  localparam int OPC_W   = 8;
  localparam int BYTE_W  = 8;
  localparam int LANES   = 4;
  localparam int ADDR_W  = 32;
  localparam int CNT_W   = 6;
  localparam int TX_W    = OPC_W + ADDR_W;
  localparam logic [OPC_W-1:0] OPC_NORMAL = 8'h03;
  localparam logic [OPC_W-1:0] OPC_FAST   = 8'h0B;

  typedef enum logic [2:0] {PH_IDLE, PH_OPC, PH_ADDR, PH_DUMMY, PH_DATA} phase_e;

  // lane widths encoded as log2: 0 = one lane, 1 = two, 2 = four
  typedef struct packed {
    logic [OPC_W-1:0] opcode;
    logic [1:0]       addr_lw;
    logic [1:0]       data_lw;
    logic [3:0]       dummy;
    logic             wide_addr;
  } rd_plan_t;

  function automatic logic [3:0] dummy_clocks(input logic [1:0] data_lw,
                                              input logic [1:0] addr_lw,
                                              input logic fast);
    if (data_lw == 2'd0) return fast ? 4'd8 : 4'd0;
    case (addr_lw)
      2'd0:    return 4'd8;
      2'd1:    return 4'd4;
      default: return 4'd6;
    endcase
  endfunction

  function automatic rd_plan_t decode_mode(input logic [4:0] cfg, input logic fast,
                                           input logic [OPC_W-1:0] s3,
                                           input logic [OPC_W-1:0] s4);
    rd_plan_t p;
    p.wide_addr = cfg[4];
    if (cfg[2]) begin
      p.data_lw = 2'd2;
      p.addr_lw = cfg[3] ? 2'd2 : 2'd0;
      p.opcode  = s4;
    end else if (cfg[0]) begin
      p.data_lw = 2'd1;
      p.addr_lw = cfg[1] ? 2'd1 : 2'd0;
      p.opcode  = s3;
    end else begin
      p.data_lw = 2'd0;
      p.addr_lw = 2'd0;
      p.opcode  = fast ? OPC_FAST : OPC_NORMAL;
    end
    p.dummy = dummy_clocks(p.data_lw, p.addr_lw, fast);
    return p;
  endfunction

  function automatic logic [CNT_W-1:0] phase_edges(input logic [6:0] bits,
                                                   input logic [1:0] lw);
    return CNT_W'(bits >> lw);
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] lw);
    case (lw)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/frs_mode_dec.sv
module frs_mode_dec
  import frs_pkg::*;
(
  input  logic [4:0]       bus_cfg,
  input  logic             fast_rd,
  input  logic [OPC_W-1:0] op_slot3,
  input  logic [OPC_W-1:0] op_slot4,
  output rd_plan_t         plan
);
  always_comb plan = decode_mode(bus_cfg, fast_rd, op_slot3, op_slot4);
endmodule

// File: rtl/frs_phase_ctl.sv
module frs_phase_ctl
  import frs_pkg::*;
#(
  parameter int OPC_BITS  = OPC_W,
  parameter int ADDR_BITS = ADDR_W,
  parameter int DATA_BITS = BYTE_W
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  rd_plan_t plan_in,
  output phase_e   phase,
  output rd_plan_t plan,
  output logic     accept,
  output logic     rise,
  output logic     fall,
  output logic     done,
  output logic     sck
);
  localparam int NARROW_BITS = ADDR_BITS - BYTE_W;

  logic             half;
  logic [CNT_W-1:0] cnt;
  logic             active;
  logic             last_edge;
  logic [CNT_W-1:0] addr_edges, data_edges;

  assign active     = (phase != PH_IDLE);
  assign accept     = start && !active;
  assign rise       = active && !half;
  assign fall       = active && half;
  assign last_edge  = fall && (cnt == '0);
  assign done       = last_edge && (phase == PH_DATA);
  assign sck        = half;
  assign addr_edges = phase_edges(plan.wide_addr ? 7'(ADDR_BITS) : 7'(NARROW_BITS), plan.addr_lw);
  assign data_edges = phase_edges(7'(DATA_BITS), plan.data_lw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      plan  <= '0;
      half  <= 1'b0;
      cnt   <= '0;
    end else if (accept) begin
      phase <= PH_OPC;
      plan  <= plan_in;
      half  <= 1'b0;
      cnt   <= CNT_W'(OPC_BITS - 1);
    end else if (active) begin
      half <= ~half;
      if (fall) begin
        if (cnt != '0) begin
          cnt <= cnt - CNT_W'(1);
        end else begin
          unique case (phase)
            PH_OPC: begin
              phase <= PH_ADDR;
              cnt   <= addr_edges - CNT_W'(1);
            end
            PH_ADDR: begin
              if (plan.dummy != '0) begin
                phase <= PH_DUMMY;
                cnt   <= CNT_W'(plan.dummy) - CNT_W'(1);
              end else begin
                phase <= PH_DATA;
                cnt   <= data_edges - CNT_W'(1);
              end
            end
            PH_DUMMY: begin
              phase <= PH_DATA;
              cnt   <= data_edges - CNT_W'(1);
            end
            default: phase <= PH_IDLE;
          endcase
        end
      end
    end
  end

  // R10
  idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sck);
  // R2
  end_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(phase == PH_DATA));
  // R9
  plan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(plan));
endmodule

// File: rtl/frs_shift.sv
module frs_shift
  import frs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide_addr,
  input  phase_e            phase,
  input  logic [1:0]        addr_lw,
  input  logic [1:0]        data_lw,
  input  logic              rise,
  input  logic              fall,
  input  logic              done,
  input  logic [LANES-1:0]  io_in,
  output logic [LANES-1:0]  io_out,
  output logic [LANES-1:0]  io_oe,
  output logic [BYTE_W-1:0] rd_data
);
  logic [TX_W-1:0]   tx;
  logic [BYTE_W-1:0] rx;
  logic [2:0]        step;

  always_comb begin
    unique case (phase)
      PH_OPC:  step = 3'd1;
      PH_ADDR: step = 3'(lane_mask(addr_lw) == 4'b1111 ? 4 : (addr_lw == 2'd1 ? 2 : 1));
      default: step = 3'd0;
    endcase
  end

  always_comb begin
    io_out = '0;
    io_oe  = '0;
    unique case (phase)
      PH_OPC: begin
        io_out = {3'b000, tx[TX_W-1]};
        io_oe  = 4'b0001;
      end
      PH_ADDR: begin
        io_oe = lane_mask(addr_lw);
        case (addr_lw)
          2'd0:    io_out = {3'b000, tx[TX_W-1]};
          2'd1:    io_out = {2'b00, tx[TX_W-1 -: 2]};
          default: io_out = tx[TX_W-1 -: 4];
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx      <= '0;
      rx      <= '0;
      rd_data <= '0;
    end else begin
      if (load)
        tx <= wide_addr ? {opcode, addr}
                        : {opcode, addr[ADDR_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
      else if (fall)
        tx <= tx << step;
      if (rise && phase == PH_DATA) begin
        case (data_lw)
          2'd0:    rx <= {rx[BYTE_W-2:0], io_in[1]};
          2'd1:    rx <= {rx[BYTE_W-3:0], io_in[1:0]};
          default: rx <= {rx[BYTE_W-5:0], io_in};
        endcase
      end
      if (done) rd_data <= rx;
    end
  end

  // R7
  rx_lanes_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DUMMY || phase == PH_DATA) |-> io_oe == '0);
  // R3
  opcode_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OPC) |-> io_oe == 4'b0001);
  // R10
  idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (io_oe == '0 && io_out == '0));
endmodule

// File: rtl/flash_read_seq.sv
module flash_read_seq
  import frs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [4:0]        bus_cfg,
  input  logic              fast_rd,
  input  logic [7:0]        addr_b0,
  input  logic [7:0]        addr_b1,
  input  logic [7:0]        addr_b2,
  input  logic [7:0]        addr_b3,
  input  logic [7:0]        op_slot3,
  input  logic [7:0]        op_slot4,
  output logic              busy,
  output logic [7:0]        rd_data,
  output logic              sck,
  output logic              cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in
);
  rd_plan_t plan_in, plan;
  phase_e   phase;
  logic     accept, rise, fall, done;

  frs_mode_dec i_dec (
    .bus_cfg (bus_cfg), .fast_rd (fast_rd),
    .op_slot3(op_slot3), .op_slot4(op_slot4), .plan(plan_in)
  );

  frs_phase_ctl i_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .plan_in(plan_in),
    .phase(phase), .plan(plan), .accept(accept), .rise(rise),
    .fall(fall), .done(done), .sck(sck)
  );

  frs_shift i_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .opcode(plan_in.opcode),
    .addr({addr_b3, addr_b2, addr_b1, addr_b0}), .wide_addr(plan_in.wide_addr),
    .phase(phase), .addr_lw(plan.addr_lw), .data_lw(plan.data_lw),
    .rise(rise), .fall(fall), .done(done), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .rd_data(rd_data)
  );

  assign busy = (phase != PH_IDLE);
  assign cs_n = ~busy;

  // R8
  sck_only_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  // R2
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
endmodule

// File: tb/test_flash_read_seq.sv
module test_flash_read_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0, fast_rd = 1'b0;
  logic [4:0] bus_cfg = '0;
  logic [7:0] addr_b0 = '0, addr_b1 = '0, addr_b2 = '0, addr_b3 = '0;
  logic [7:0] op_slot3 = 8'h3B, op_slot4 = 8'h6B;
  logic       busy, sck, cs_n;
  logic [7:0] rd_data;
  logic [3:0] io_out, io_oe;
  logic [3:0] io_in = '0;

  int checks = 0, errors = 0;
  bit finished = 0;

  // bench-side expectations and flash model state
  int exp_dl, exp_al, exp_dummy, exp_abits, edge_k, oe_err;
  logic [7:0]  exp_op, exp_data, got_op;
  logic [31:0] exp_addr, got_addr;

  flash_read_seq i_flash_read_seq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // flash model: capture on rising sck
  always @(posedge sck) begin
    if (edge_k < 8) begin
      got_op = {got_op[6:0], io_out[0]};
      if (io_oe !== 4'b0001) oe_err++;
    end else if (edge_k < 8 + exp_abits / exp_al) begin
      if (exp_al == 1) begin
        got_addr = {got_addr[30:0], io_out[0]};
        if (io_oe !== 4'b0001) oe_err++;
      end else if (exp_al == 2) begin
        got_addr = {got_addr[29:0], io_out[1:0]};
        if (io_oe !== 4'b0011) oe_err++;
      end else begin
        got_addr = {got_addr[27:0], io_out};
        if (io_oe !== 4'b1111) oe_err++;
      end
    end else if (io_oe !== 4'b0000) oe_err++;
    edge_k++;
  end

  // flash model: drive data after falling sck, junk on unused lanes
  always @(negedge sck) begin
    int ds, j;
    ds = 8 + exp_abits / exp_al + exp_dummy;
    if (edge_k >= ds && edge_k < ds + 8 / exp_dl) begin
      j = edge_k - ds;
      if (exp_dl == 1) begin
        logic b;
        b = exp_data[7 - j];
        io_in = {~b, ~b, b, ~b};
      end else if (exp_dl == 2) begin
        logic [1:0] c;
        c = exp_data[7 - 2*j -: 2];
        io_in = {~c, c};
      end else begin
        io_in = exp_data[7 - 4*j -: 4];
      end
    end
  end

  task automatic run_txn(input logic [4:0] cfg, input logic fast,
                         input logic [31:0] a, input bit disturb);
    int n;
    int total;
    bus_cfg = cfg; fast_rd = fast;
    {addr_b3, addr_b2, addr_b1, addr_b0} = a;
    op_slot3 = 8'h3B ^ {3'b0, cfg}; op_slot4 = 8'h6B ^ {cfg, 3'b0};
    // own restatement of the mode rules (R4, R6, R3)
    exp_dl    = cfg[2] ? 4 : (cfg[0] ? 2 : 1);
    exp_al    = (cfg[2] && cfg[3]) ? 4 : ((!cfg[2] && cfg[0] && cfg[1]) ? 2 : 1);
    exp_dummy = (exp_dl == 1) ? (fast ? 8 : 0) : (exp_al == 1 ? 8 : (exp_al == 2 ? 4 : 6));
    exp_op    = (exp_dl == 4) ? op_slot4 : (exp_dl == 2) ? op_slot3 : (fast ? 8'h0B : 8'h03);
    exp_abits = cfg[4] ? 32 : 24;
    exp_addr  = cfg[4] ? a : {8'h00, a[23:0]};
    exp_data  = a[7:0] ^ a[23:16] ^ 8'h3C ^ {cfg, fast, 2'b01};
    total     = 8 + exp_abits / exp_al + exp_dummy + 8 / exp_dl;
    edge_k = 0; oe_err = 0; got_op = '0; got_addr = '0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy === 1'b1 && cs_n === 1'b0, "R2", "busy/cs_n after start", {busy, cs_n}, 2'b10);
    if (disturb) begin
      repeat (20) @(negedge clk);
      bus_cfg = cfg ^ 5'h15; fast_rd = ~fast;
      {addr_b3, addr_b2, addr_b1, addr_b0} = ~a;
      op_slot3 = ~op_slot3; op_slot4 = ~op_slot4;
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    check(!busy, "R2", "busy self-clear", busy, 0);
    check(got_op == exp_op, "R3", "opcode", got_op, exp_op);
    check(got_addr == exp_addr, "R5", "address", got_addr, exp_addr);
    check(edge_k == total, "R6", "sck edge count (dummy)", edge_k, total);
    check(rd_data == exp_data, "R7", "rd_data", rd_data, exp_data);
    check(oe_err == 0, "R7", "io_oe per phase", oe_err, 0);
    repeat (4) @(negedge clk);
    check(cs_n && !sck && io_oe == 0 && io_out == 0, "R10", "idle bus",
          {cs_n, sck, io_oe, io_out}, 10'h200);
    if (disturb)
      check(edge_k == total && rd_data == exp_data, "R9", "start while busy ignored",
            edge_k, total);
  endtask

  initial begin
    logic [31:0] addrs [2];
    addrs[0] = 32'hC3A5_1E96;
    addrs[1] = 32'h1F00_80FF;
    exp_dl = 1; exp_al = 1; exp_dummy = 0; exp_abits = 24;
    edge_k = 0; oe_err = 0; got_op = '0; got_addr = '0; exp_data = '0;
    repeat (3) @(negedge clk);
    check(cs_n === 1'b1 && sck === 1'b0 && busy === 1'b0 && rd_data === 8'h00 && io_oe === 4'h0,
          "R1", "reset state", {cs_n, sck, busy, rd_data, io_oe}, 15'h4000);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 32; c++)
      for (int f = 0; f < 2; f++)
        for (int a = 0; a < 2; a++)
          run_txn(5'(c), f[0], addrs[a], (c % 7 == 3) && (a == 1));
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R2 watchdog expired: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule